// File: doc/BRIEF.md
# Zoned Logical Block to Disk Geometry Translator

This block turns a linear logical block number into the physical coordinates of a zoned disk: a surface, a track (the cylinder index, counted across the whole disk) and a sector within that track. Tracks are grouped into recording zones. Each zone has its own sectors-per-track count. The last few cylinders of every zone are held back as spares, so the logical space skips over them. Logical numbers start at 0, and a number at or past the formatted capacity is reported as out of range.

A request arrives on a valid/ready pair and is captured only while the block is idle. The block picks the zone by comparing the number against the running sum of zone capacities. It then finds the track offset and the sector with a shift-subtract divider, one quotient bit per cycle. A second pass of the same divider splits the track offset into a cylinder and a surface. The answer stays on the outputs, unchanged, until the consumer takes it. Zone cylinder counts, spare counts, sectors per track and the surface count are all parameters.

Top module: `lba_geom_xlate`

## Requirements
- R1: After reset, `resp_valid` is 0 and `req_ready` is 1.
- R2: The zone is the lowest zone whose running capacity end exceeds the block number. A zone holds (cylinders minus spares) x surfaces x sectors-per-track blocks. The first block of any zone maps to surface 0, the zone's first cylinder and sector 0.
- R3: Zones lie on the disk in index order. The first cylinder of a zone is the sum of the cylinder counts, spares included, of all zones before it. The spares are the highest cylinders of each zone and never appear in a result.
- R4: Within a zone, consecutive blocks fill sectors 0 to spt-1 first, then step to the next surface of the same cylinder, then to the next cylinder. A valid result always has sector < spt of its zone and surface < the surface count.
- R5: A block number greater than or equal to the total capacity gives `resp_oor` = 1 with surface, track and sector all 0.
- R6: While `resp_valid` is 1 and `resp_ready` is 0, all result outputs hold their values.
- R7: Only one request is in flight. `req_ready` is 0 from the cycle after an accepted request until the cycle after the result is taken. A request offered during that time is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be captured |
| req_lba | input | LBA_W | Logical block number |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Consumer takes the result |
| resp_surface | output | SURF_W | Surface index |
| resp_track | output | CYL_W | Track (cylinder) index across the disk |
| resp_sector | output | SEC_W | Sector within the track |
| resp_oor | output | 1 | Block number beyond formatted capacity |

## Verification
Two things can coincide in one cycle: a finished result being held back by the consumer, and a new request waiting at the input. The bench produces a result and keeps `resp_ready` low for several cycles while a different request is driven with `req_valid` high. In each stalled cycle it checks that the result outputs are unchanged and that `req_ready` stays low. After the result is released, the waiting request must be captured and translated to its own correct triple, which shows it was not consumed or damaged during the stall.

// File: rtl/lba_geom_xlate.sv
module lba_geom_xlate #(
  parameter int SURFACES = 4,
  parameter int ZONES = 3,
  parameter int LBA_W = 10,
  parameter int ZCYL [ZONES] = '{6, 5, 4},
  parameter int ZSPARE [ZONES] = '{1, 1, 1},
  parameter int ZSPT [ZONES] = '{12, 10, 8}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic [LBA_W-1:0] req_lba,
  output logic resp_valid,
  input  logic resp_ready,
  output logic [((SURFACES > 1) ? $clog2(SURFACES) : 1)-1:0] resp_surface,
  output logic [$clog2(lba_geom_total_cyl())-1:0] resp_track,
  output logic [((lba_geom_max_spt() > 1) ? $clog2(lba_geom_max_spt()) : 1)-1:0] resp_sector,
  output logic resp_oor
);

  function automatic int lba_geom_total_cyl();
    int s = 0;
    for (int i = 0; i < ZONES; i++) s += ZCYL[i];
    return s;
  endfunction

  function automatic int lba_geom_max_spt();
    int m = 1;
    for (int i = 0; i < ZONES; i++) if (ZSPT[i] > m) m = ZSPT[i];
    return m;
  endfunction

  function automatic int zone_cap(int z);
    return (ZCYL[z] - ZSPARE[z]) * SURFACES * ZSPT[z];
  endfunction

  function automatic int zone_end(int z);
    int s = 0;
    for (int i = 0; i <= z; i++) s += zone_cap(i);
    return s;
  endfunction

  function automatic int zone_cyl0(int z);
    int s = 0;
    for (int i = 0; i < z; i++) s += ZCYL[i];
    return s;
  endfunction

  localparam int SURF_W = (SURFACES > 1) ? $clog2(SURFACES) : 1;
  localparam int CYL_W  = $clog2(lba_geom_total_cyl());
  localparam int SEC_W  = (lba_geom_max_spt() > 1) ? $clog2(lba_geom_max_spt()) : 1;
  localparam int CNT_W  = $clog2(LBA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2, S_DONE} state_t;
  state_t state;

  logic [LBA_W-1:0]  num, rem, div;
  logic [CNT_W-1:0]  cnt;
  logic [CYL_W-1:0]  cyl0;
  logic [SURF_W-1:0] surf_r;
  logic [CYL_W-1:0]  trk_r;
  logic [SEC_W-1:0]  sec_r;
  logic              oor_r;

  logic              oor_c;
  logic [LBA_W-1:0]  z_base, z_spt;
  logic [CYL_W-1:0]  z_cyl0;

  always_comb begin
    oor_c  = 1'b1;
    z_base = '0;
    z_spt  = LBA_W'(1);
    z_cyl0 = '0;
    for (int i = ZONES - 1; i >= 0; i--) begin
      if (int'(req_lba) < zone_end(i)) begin
        oor_c  = 1'b0;
        z_base = LBA_W'(zone_end(i) - zone_cap(i));
        z_spt  = LBA_W'(ZSPT[i]);
        z_cyl0 = CYL_W'(zone_cyl0(i));
      end
    end
  end

  logic [LBA_W:0]   rem_sh;
  logic             ge;
  logic [LBA_W-1:0] rem_nx, num_nx;
  logic             last;

  assign rem_sh = {rem, num[LBA_W-1]};
  assign ge     = rem_sh >= {1'b0, div};
  assign rem_nx = ge ? LBA_W'(rem_sh - {1'b0, div}) : rem_sh[LBA_W-1:0];
  assign num_nx = {num[LBA_W-2:0], ge};
  assign last   = cnt == CNT_W'(LBA_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      num    <= '0;
      rem    <= '0;
      div    <= '0;
      cnt    <= '0;
      cyl0   <= '0;
      surf_r <= '0;
      trk_r  <= '0;
      sec_r  <= '0;
      oor_r  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          oor_r <= oor_c;
          if (oor_c) begin
            surf_r <= '0;
            trk_r  <= '0;
            sec_r  <= '0;
            state  <= S_DONE;
          end else begin
            num   <= req_lba - z_base;
            rem   <= '0;
            div   <= z_spt;
            cyl0  <= z_cyl0;
            cnt   <= '0;
            state <= S_DIV1;
          end
        end
        S_DIV1: begin
          num <= num_nx;
          cnt <= cnt + 1'b1;
          rem <= rem_nx;
          if (last) begin
            sec_r <= rem_nx[SEC_W-1:0];
            rem   <= '0;
            div   <= LBA_W'(SURFACES);
            cnt   <= '0;
            state <= S_DIV2;
          end
        end
        S_DIV2: begin
          num <= num_nx;
          cnt <= cnt + 1'b1;
          rem <= rem_nx;
          if (last) begin
            surf_r <= rem_nx[SURF_W-1:0];
            trk_r  <= cyl0 + num_nx[CYL_W-1:0];
            state  <= S_DONE;
          end
        end
        default: if (resp_ready) state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = state == S_IDLE;
  assign resp_valid   = state == S_DONE;
  assign resp_surface = surf_r;
  assign resp_track   = trk_r;
  assign resp_sector  = sec_r;
  assign resp_oor     = oor_r;

  function automatic logic in_spare(logic [CYL_W-1:0] t);
    logic r = 1'b0;
    for (int i = 0; i < ZONES; i++)
      if (int'(t) >= zone_cyl0(i) + ZCYL[i] - ZSPARE[i] && int'(t) < zone_cyl0(i) + ZCYL[i])
        r = 1'b1;
    return r;
  endfunction

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> req_ready && !resp_valid);

  p_no_spare_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_oor |-> !in_spare(resp_track));

  p_surf_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_oor |-> int'(resp_surface) < SURFACES && int'(resp_sector) < lba_geom_max_spt());

  p_oor_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_oor |-> resp_surface == '0 && resp_track == '0 && resp_sector == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_surface) && $stable(resp_track)
      && $stable(resp_sector) && $stable(resp_oor));

  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n) !(req_ready && resp_valid));

endmodule

// File: tb/lba_geom_xlate_test.sv
module lba_geom_xlate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic resp_ready = 1'b0;
  logic [9:0] req_lba = '0;
  logic req_ready, resp_valid, resp_oor;
  logic [1:0] resp_surface;
  logic [3:0] resp_track, resp_sector;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  lba_geom_xlate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lba(req_lba), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_surface(resp_surface), .resp_track(resp_track),
    .resp_sector(resp_sector), .resp_oor(resp_oor)
  );

  // {lba, oor, surface, track, sector}; zones: 12 spt cyl 0-4, 10 spt cyl 6-9, 8 spt cyl 11-13
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {10'd0,    1'b0, 2'd0, 4'd0,  4'd0},
    {10'd11,   1'b0, 2'd0, 4'd0,  4'd11},
    {10'd12,   1'b0, 2'd1, 4'd0,  4'd0},
    {10'd47,   1'b0, 2'd3, 4'd0,  4'd11},
    {10'd48,   1'b0, 2'd0, 4'd1,  4'd0},
    {10'd239,  1'b0, 2'd3, 4'd4,  4'd11},
    {10'd240,  1'b0, 2'd0, 4'd6,  4'd0},
    {10'd285,  1'b0, 2'd0, 4'd7,  4'd5},
    {10'd399,  1'b0, 2'd3, 4'd9,  4'd9},
    {10'd400,  1'b0, 2'd0, 4'd11, 4'd0},
    {10'd437,  1'b0, 2'd0, 4'd12, 4'd5},
    {10'd495,  1'b0, 2'd3, 4'd13, 4'd7},
    {10'd496,  1'b1, 2'd0, 4'd0,  4'd0},
    {10'd1023, 1'b1, 2'd0, 4'd0,  4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_res(input string req, input logic [20:0] v);
    chk(req, {28'd0, resp_oor, resp_surface, 1'b0},
        {28'd0, v[10], v[9:8], 1'b0});
    chk(req, {24'd0, resp_track, resp_sector}, {24'd0, v[7:4], v[3:0]});
  endtask

  task automatic issue(input logic [9:0] lba);
    req_lba = lba;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
  endtask

  task automatic take();
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad + 0);
    $finish;
  end

  initial begin
    logic [20:0] held;
    repeat (3) @(negedge clk);
    chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][20:11]);
      check_res(VEC[i][10] ? "R5 out of range" : "R2 R3 R4 translate", VEC[i]);
      take();
    end

    // R6 and R7: result stalled while another request waits
    issue(10'd285);
    held = VEC[7];
    req_lba = 10'd12;
    req_valid = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_res("R6 hold under stall", held);
      chk("R7 no capture while pending", {31'd0, req_ready}, 32'd0);
    end
    take();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    check_res("R7 waiting request translated", {10'd12, 1'b0, 2'd1, 4'd0, 4'd0});
    take();
    chk("R7 ready after take", {31'd0, req_ready}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule